// File: doc/BRIEF.md
# Shared-Latch 16-bit Register Bridge

This block lets a CPU with an 8-bit data bus read and write a small set of 16-bit peripheral registers without tearing. The set holds one free-running counter, a parameterised number of compare registers and one capture register. Each register occupies two byte addresses. A single byte-wide holding latch is shared by all of them.

A write to a high byte only parks the data in the latch. The following low-byte write commits the latch and the bus byte together, in one clock edge. A low-byte read of the counter or the capture register returns the live low byte. On the same edge it parks that register's high byte in the latch, so a later high-byte read returns a value consistent with the low byte. Compare registers are read directly, with both bytes taken from storage.

A capture input copies the running counter into the capture register. This lets the atomic read path be exercised against a moving value.

Top module: `wide_reg_bridge`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, every compare register, the capture register and the latch are cleared to zero.
- R2: Register k sits at byte address 2k (low byte) and 2k+1 (high byte). Index 0 is the counter, indices 1..NUM_CMP are the compare registers, and index NUM_CMP+1 is the capture register.
- R3: A write to any valid high-byte address loads `bus_wdata` into the latch and leaves every 16-bit register unchanged.
- R4: A write to a valid low-byte address sets that register to {latch, `bus_wdata`} at the next clock edge.
- R5: A read of a low byte returns bits 7:0 of the live register. For the counter or the capture register, when `bus_we` is low, that register's bits 15:8 are copied into the latch at the same edge.
- R6: A read of the high byte of the counter or the capture register returns the latch, not the live high byte.
- R7: A read of either byte of a compare register returns that byte of the register directly and leaves the latch unchanged.
- R8: The counter adds one at every clock edge, except when a low-byte write to it commits; in that case the written value is loaded instead.
- R9: A high `cap_strobe` loads the current counter value into the capture register at the next edge. A simultaneous low-byte write to the capture register takes priority.
- R10: Addresses above 2·NUM_CMP+3 read as zero, and writes to them change neither the latch nor any register.
- R11: `bus_rdata` is zero whenever `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Byte address |
| bus_wdata | input | BYTE_W (8) | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | BYTE_W (8) | Read data, combinational during `bus_re` |
| cap_strobe | input | 1 | Copies the counter into the capture register |

## Verification
The bench builds the block with its defaults: 8-bit bytes and three compare registers. This gives a 4-bit address space, and six of its sixteen addresses are unused, so out-of-range reads and writes can be driven. Those defaults also make a low-byte counter value of 0xFF easy to load. The next edge then carries into the high byte between the low and high reads, which shows that the latch preserves the old high byte.

// File: rtl/bridge_pkg.sv
`timescale 1ns/1ps
package bridge_pkg;
  // Which kind of 16-bit register an address selects
  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_CNT  = 2'd1,
    RK_CMP  = 2'd2,
    RK_CAP  = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/addr_decode.sv
`timescale 1ns/1ps
module addr_decode
  import bridge_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_CMP = 3,
  localparam int IDX_W  = ADDR_W - 1
)(
  input  logic [ADDR_W-1:0] addr,
  output logic              is_hi,
  output logic [IDX_W-1:0]  idx,
  output reg_kind_e         kind
);
  assign is_hi = addr[0];
  assign idx   = addr[ADDR_W-1:1];

  always_comb begin
    if (idx == '0)                         kind = RK_CNT;
    else if (idx <= IDX_W'(NUM_CMP))       kind = RK_CMP;
    else if (idx == IDX_W'(NUM_CMP + 1))   kind = RK_CAP;
    else                                   kind = RK_NONE;
  end
endmodule

// File: rtl/byte_latch.sv
`timescale 1ns/1ps
module byte_latch #(
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         snap_en,
  input  logic [W-1:0] snap_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (wr_en)   q <= wr_val;
    else if (snap_en) q <= snap_val;
  end
endmodule

// File: rtl/load_counter.sv
`timescale 1ns/1ps
module load_counter #(
  parameter int W = 16
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (load_en) count <= load_val;
    else              count <= count + W'(1);
  end
endmodule

// File: rtl/word_store.sv
`timescale 1ns/1ps
module word_store #(
  parameter int W = 16
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         cap_en,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (load_en) q <= load_val;
    else if (cap_en)  q <= cap_val;
  end
endmodule

// File: rtl/wide_reg_bridge.sv
`timescale 1ns/1ps
module wide_reg_bridge
  import bridge_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int NUM_CMP = 3,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int ADDR_W = $clog2(2 * (NUM_CMP + 2))
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              cap_strobe
);
  localparam int IDX_W = ADDR_W - 1;

  logic                          is_hi;
  logic [IDX_W-1:0]              idx;
  reg_kind_e                     kind;
  logic [BYTE_W-1:0]             hi_q;
  logic [WORD_W-1:0]             cnt_q;
  logic [WORD_W-1:0]             cap_q;
  logic [NUM_CMP-1:0][WORD_W-1:0] cmp_q;
  logic [WORD_W-1:0]             sel_word;
  logic [WORD_W-1:0]             commit_val;
  logic                          hi_wr, commit, snap;

  addr_decode #(.ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP)) u_dec (
    .addr (bus_addr),
    .is_hi(is_hi),
    .idx  (idx),
    .kind (kind)
  );

  // Strobe qualification
  assign hi_wr      = bus_we && is_hi && (kind != RK_NONE);
  assign commit     = bus_we && !is_hi && (kind != RK_NONE);
  assign snap       = bus_re && !bus_we && !is_hi && ((kind == RK_CNT) || (kind == RK_CAP));
  assign commit_val = {hi_q, bus_wdata};

  // Live word selected by the address
  always_comb begin
    sel_word = '0;
    case (kind)
      RK_CNT: sel_word = cnt_q;
      RK_CAP: sel_word = cap_q;
      RK_CMP: begin
        for (int g = 0; g < NUM_CMP; g++)
          if (idx == IDX_W'(g + 1)) sel_word = cmp_q[g];
      end
      default: sel_word = '0;
    endcase
  end

  byte_latch #(.W(BYTE_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (hi_wr),
    .wr_val  (bus_wdata),
    .snap_en (snap),
    .snap_val(sel_word[WORD_W-1:BYTE_W]),
    .q       (hi_q)
  );

  load_counter #(.W(WORD_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load_en (commit && (kind == RK_CNT)),
    .load_val(commit_val),
    .count   (cnt_q)
  );

  generate
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
      word_store #(.W(WORD_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .load_en (commit && (kind == RK_CMP) && (idx == IDX_W'(g + 1))),
        .load_val(commit_val),
        .cap_en  (1'b0),
        .cap_val ('0),
        .q       (cmp_q[g])
      );
    end
  endgenerate

  word_store #(.W(WORD_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .load_en (commit && (kind == RK_CAP)),
    .load_val(commit_val),
    .cap_en  (cap_strobe),
    .cap_val (cnt_q),
    .q       (cap_q)
  );

  // Read data path
  always_comb begin
    if (!bus_re || (kind == RK_NONE)) bus_rdata = '0;
    else if (!is_hi)                  bus_rdata = sel_word[BYTE_W-1:0];
    else if (kind == RK_CMP)          bus_rdata = sel_word[WORD_W-1:BYTE_W];
    else                              bus_rdata = hi_q;
  end
endmodule

// File: rtl/bridge_chk.sv
`timescale 1ns/1ps
module bridge_chk #(
  parameter int BYTE_W  = 8,
  parameter int NUM_CMP = 3,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int ADDR_W = $clog2(2 * (NUM_CMP + 2))
)(
  input logic                           clk,
  input logic                           rst,
  input logic [ADDR_W-1:0]              bus_addr,
  input logic [BYTE_W-1:0]              bus_wdata,
  input logic                           bus_we,
  input logic                           bus_re,
  input logic [BYTE_W-1:0]              bus_rdata,
  input logic                           cap_strobe,
  input logic [BYTE_W-1:0]              hi_q,
  input logic [WORD_W-1:0]              cnt_q,
  input logic [WORD_W-1:0]              cap_q,
  input logic [NUM_CMP-1:0][WORD_W-1:0] cmp_q
);
  localparam int IDX_W   = ADDR_W - 1;
  localparam int CAP_IDX = NUM_CMP + 1;

  logic [IDX_W-1:0] a_idx;
  logic             a_hi, a_valid, a_cmp, cnt_lo_wr, cap_lo_wr;
  assign a_idx     = bus_addr[ADDR_W-1:1];
  assign a_hi      = bus_addr[0];
  assign a_valid   = a_idx <= IDX_W'(CAP_IDX);
  assign a_cmp     = (a_idx >= IDX_W'(1)) && (a_idx <= IDX_W'(NUM_CMP));
  assign cnt_lo_wr = bus_we && !a_hi && (a_idx == '0);
  assign cap_lo_wr = bus_we && !a_hi && (a_idx == IDX_W'(CAP_IDX));

  // R3
  hi_write_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we && a_hi && a_valid |=> hi_q == $past(bus_wdata));

  // R4
  cnt_commit_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_lo_wr |=> cnt_q == {$past(hi_q), $past(bus_wdata)});

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_lo_wr |=> cnt_q == $past(cnt_q) + WORD_W'(1));

  // R5
  snap_chk: assert property (@(posedge clk) disable iff (rst)
    bus_re && !bus_we && !a_hi && (a_idx == '0) |=> hi_q == $past(cnt_q[WORD_W-1:BYTE_W]));

  // R6
  hi_read_chk: assert property (@(posedge clk) disable iff (rst)
    bus_re && a_hi && ((a_idx == '0) || (a_idx == IDX_W'(CAP_IDX))) |-> bus_rdata == hi_q);

  // R7
  cmp_read_chk: assert property (@(posedge clk) disable iff (rst)
    bus_re && !bus_we && a_cmp |=> $stable(hi_q));

  // R9
  cap_chk: assert property (@(posedge clk) disable iff (rst)
    cap_strobe && !cap_lo_wr |=> cap_q == $past(cnt_q));

  // R10
  bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
    bus_we && !bus_re && !a_valid |=> $stable(hi_q));

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_re |-> bus_rdata == '0);

  generate
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_hold
      // R3
      cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && !a_hi && (a_idx == IDX_W'(g + 1))) |=> $stable(cmp_q[g]));
    end
  endgenerate
endmodule

bind wide_reg_bridge bridge_chk #(.BYTE_W(BYTE_W), .NUM_CMP(NUM_CMP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .cap_strobe(cap_strobe),
  .hi_q      (hi_q),
  .cnt_q     (cnt_q),
  .cap_q     (cap_q),
  .cmp_q     (cmp_q)
);

// File: tb/sim_wide_reg_bridge.sv
`timescale 1ns/1ps
module sim_wide_reg_bridge;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic       cap_strobe = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  wide_reg_bridge u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .cap_strobe(cap_strobe)
  );

  // Map: counter 0/1, compares 2/3 4/5 6/7, capture 8/9, 10..15 unused
  // Vector: {is_read, addr, wdata or expected read}
  localparam int NV = 23;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 4'd3,  8'hA5},  // R3 park A5
    {1'b1, 4'd3,  8'h00},  // R3 R7 compare high untouched, not latch
    {1'b1, 4'd2,  8'h00},  // R3
    {1'b0, 4'd2,  8'h5A},  // R4 commit A55A
    {1'b1, 4'd3,  8'hA5},  // R7
    {1'b1, 4'd2,  8'h5A},  // R4
    {1'b0, 4'd5,  8'h11},
    {1'b0, 4'd4,  8'h22},
    {1'b0, 4'd7,  8'h33},
    {1'b0, 4'd6,  8'h44},
    {1'b1, 4'd5,  8'h11},  // R2
    {1'b1, 4'd4,  8'h22},  // R2
    {1'b1, 4'd7,  8'h33},  // R2
    {1'b1, 4'd6,  8'h44},  // R2
    {1'b1, 4'd9,  8'h33},  // R6 capture high shows latch
    {1'b0, 4'd11, 8'h77},  // R10 ignored
    {1'b1, 4'd11, 8'h00},  // R10 reads zero
    {1'b1, 4'd2,  8'h5A},  // R7 no snapshot
    {1'b0, 4'd4,  8'h99},  // commits {latch,99}
    {1'b1, 4'd5,  8'h33},  // R10 R7 latch kept at 33
    {1'b1, 4'd4,  8'h99},
    {1'b1, 4'd8,  8'h00},  // R5 snapshot capture high 00
    {1'b1, 4'd9,  8'h00}   // R6
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [3:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = wr; bus_re = !wr;
    #2 rd = bus_rdata;
    @(posedge clk);
    #1 bus_we = 1'b0; bus_re = 1'b0;
  endtask

  task automatic wr_b(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] unused;
    bus_op(1'b1, a, d, unused);
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] got;
    bus_op(1'b0, a, 8'h00, got);
    check(req, got, exp);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: reads while reset is held
    rd_chk("R1 counter low", 4'd0, 8'h00);
    rd_chk("R1 compare high", 4'd3, 8'h00);
    rd_chk("R1 latch", 4'd9, 8'h00);
    rd_chk("R1 capture low", 4'd8, 8'h00);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][12]) rd_chk($sformatf("R2-R10 vector %0d", i), VEC[i][11:8], VEC[i][7:0]);
      else            wr_b(VEC[i][11:8], VEC[i][7:0]);
    end

    // R4 R8: write wins over increment, then counting resumes
    wr_b(4'd1, 8'h12);
    wr_b(4'd0, 8'h34);
    rd_chk("R4 R8 counter commit", 4'd0, 8'h34);
    rd_chk("R8 counter step", 4'd0, 8'h35);
    rd_chk("R5 R6 counter high", 4'd1, 8'h12);

    // R6: carry between low and high reads does not tear
    wr_b(4'd1, 8'h12);
    wr_b(4'd0, 8'hFF);
    rd_chk("R5 counter low FF", 4'd0, 8'hFF);
    rd_chk("R6 latched high across carry", 4'd1, 8'h12);
    rd_chk("R8 counter after carry", 4'd0, 8'h01);

    // R9: capture strobe copies counter
    wr_b(4'd1, 8'h40);
    wr_b(4'd0, 8'h00);
    @(negedge clk) cap_strobe = 1'b1;
    @(posedge clk) #1 cap_strobe = 1'b0;
    rd_chk("R9 capture low", 4'd8, 8'h00);
    rd_chk("R9 capture high", 4'd9, 8'h40);

    // R9: CPU commit beats simultaneous strobe
    wr_b(4'd9, 8'hAB);
    @(negedge clk);
    bus_addr = 4'd8; bus_wdata = 8'hCD; bus_we = 1'b1; cap_strobe = 1'b1;
    @(posedge clk) #1 begin bus_we = 1'b0; cap_strobe = 1'b0; end
    rd_chk("R9 priority low", 4'd8, 8'hCD);
    rd_chk("R9 priority high", 4'd9, 8'hAB);

    // R11: no read strobe gives zero even on a non-zero register
    @(negedge clk);
    bus_addr = 4'd2;
    #2 check("R11 idle on compare", bus_rdata, 8'h00);
    bus_addr = 4'd9;
    #2 check("R11 idle on capture", bus_rdata, 8'h00);

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule